// File: doc/BRIEF.md
# Serial VID Send-Byte Receiver

This block listens on a two-wire serial bus (I2C send-byte transactions only) and keeps the voltage-reference codes for two regulator outputs. It oversamples SCL and SDA with the system clock and recognises start and stop conditions. It shifts in an address byte and acknowledges it only when the byte names one of its two targets. It then shifts in one data byte, acknowledges it, and either loads a new 7-bit code for the addressed output or raises a VID-off flag. Output 1's code n stands for 1.6125 V minus n × 12.5 mV (codes 0x00 to 0x2F), and the tracking rail follows at half that value. Output 2's code n stands for a margin of +26.67 % minus n × 1.67 %, so code 0x10 means no margin.

Before the first command arrives, and while enable is low, output 1's code follows two VID strap pins. Two further ID strap pins place the controller at one of four bus identities, so several receivers can share one bus. The receiver sits on the bus beside other devices. It only pulls SDA low (through `sda_pd_o`) during the acknowledge slots of a transaction addressed to it.

The state machine has these states:
- IDLE: bus free.
- ADDR: shifting in the address byte.
- ADDR_ACK: holding SDA low for one SCL low phase.
- DATA: shifting in the data byte.
- DATA_ACK: second acknowledge.
- HOLD: transaction finished or not addressed to it; wait for the bus.

Its transitions are:
- start (from any state) → ADDR.
- stop (from any state) → IDLE.
- ADDR → ADDR_ACK on the SCL fall after the eighth bit when the address hits, or ADDR → HOLD when it misses.
- ADDR_ACK → DATA on the next SCL fall.
- DATA → DATA_ACK on the SCL fall after the eighth bit. The data byte is applied at this transition.
- DATA_ACK → HOLD on the next SCL fall.

Top module: `svid_rx`

## Requirements
- R1: A start is SDA falling while SCL is high, and it begins a new address byte from any state, including in the middle of a byte. A stop (SDA rising while SCL is high), or a new start, ends an incomplete transfer without changing any code.
- R2: The address byte is acknowledged by holding `sda_pd_o` high through the following SCL high phase. It is acknowledged only when its bits [7:5] are 110, bits [4:3] equal `{id_strap_i[1], id_strap_i[0]}`, bit 0 (write) is 0, and bits [2:1] are 10 (output 1) or 01 (output 2). With both straps high these bytes are 0xDC and 0xDA.
- R3: Any other address byte, a read bit included, gets no acknowledge. The data byte that follows is neither acknowledged nor applied.
- R4: After an acknowledged address, the data byte is acknowledged in the same way as the address.
- R5: Data bit 7 is ignored. When data bit 6 is 0, `{0, data[5:0]}` is loaded into the addressed code (`code1_o` for bits [2:1] = 10, `code2_o` for 01), and the other code is left unchanged.
- R6: A data byte with bit 6 set raises `vid_off_o` and leaves both codes unchanged. The next data byte with bit 6 clear lowers `vid_off_o`.
- R7: `code_stb_o` is high for exactly one clock per applied data byte. The strobe and the new values appear on the third rising clock edge after SCL falls at the end of the eighth data bit.
- R8: While `enable_i` is low and no data byte has been applied, `code1_o` takes the value set by `vid_strap_i` on the next clock edge: 00 gives 0x2D (1.05 V), 01 gives 0x21 (1.2 V), 10 gives 0x15 (1.35 V), 11 gives 0x09 (1.5 V).
- R9: Once `enable_i` is high, or once any data byte has been applied, `vid_strap_i` has no effect on `code1_o`.
- R10: Reset gives `code1_o` = 0x09, `code2_o` = 0x10 (0.75 V tracking, no margin), `vid_off_o` = 0, `code_stb_o` = 0 and `sda_pd_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| id_strap_i | input | 2 | Controller identity straps, [1] compared to address bit 4, [0] to bit 3 |
| vid_strap_i | input | 2 | Boot code select for output 1 |
| enable_i | input | 1 | Regulator enable; high freezes the strap default |
| sda_pd_o | output | 1 | High pulls SDA low (acknowledge) |
| code1_o | output | 7 | Voltage code of output 1 |
| code2_o | output | 7 | Margin code of output 2 |
| vid_off_o | output | 1 | Last applied data byte was a VID-off command |
| code_stb_o | output | 1 | One-cycle pulse when a data byte is applied |

## Verification
Each bus edge passes through a two-flop synchroniser and a one-cycle edge detector. A data byte's effect on the codes, the off flag and the strobe is therefore due on the third clock edge after the bench drives SCL low at the end of the eighth data bit. The bench queues each expected update with exactly that due cycle and compares all four results after every clock edge. The strap default (R8) is due one edge after the strap or enable change. The acknowledge output is due three edges after SCL falls, so the bench samples it in the middle of the following SCL high phase, well after it has settled.

// File: rtl/svid_pkg.sv
package svid_pkg;

    localparam int BYTE_W = 8;
    localparam int VID_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_HOLD
    } rx_state_t;

    typedef enum logic {
        TGT_OUT1,
        TGT_OUT2
    } target_t;

    // fixed address fields around the identity straps
    localparam logic [2:0] ADDR_TOP  = 3'b110;
    localparam logic [1:0] SEL_OUT1  = 2'b10;
    localparam logic [1:0] SEL_OUT2  = 2'b01;

    localparam logic [VID_W-1:0] CODE1_RST = 7'h09;
    localparam logic [VID_W-1:0] CODE2_RST = 7'h10;

    // boot code for output 1 from the VID straps
    function automatic logic [VID_W-1:0] strap_code(input logic [1:0] sel);
        logic [VID_W-1:0] c;
        unique case (sel)
            2'b00: c = 7'h2D;
            2'b01: c = 7'h21;
            2'b10: c = 7'h15;
            default: c = 7'h09;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/svid_sync.sv
module svid_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= '1;
                else        stage <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= '1;
                else        stage <= {stage[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];

endmodule

// File: rtl/svid_fsm.sv
module svid_fsm
    import svid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [1:0]       id_strap,
    output logic             sda_pd,
    output logic             byte_valid,
    output logic [VID_W-1:0] byte_q,
    output target_t          tgt
);

    logic      scl_q, sda_q;
    logic      scl_rise, scl_fall, start_ev, stop_ev;
    rx_state_t state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic      byte_done;
    logic      addr_hit;
    target_t   addr_tgt;

    // previous line levels for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_ev  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev   = scl_s & scl_q & ~sda_q & sda_s;
    assign byte_done = scl_fall && (cnt == CNT_W'(BYTE_W));

    // address decode against the strap identity
    always_comb begin
        addr_hit = 1'b0;
        addr_tgt = TGT_OUT1;
        if (shreg[0] == 1'b0 && shreg[7:5] == ADDR_TOP && shreg[4:3] == id_strap) begin
            if (shreg[2:1] == SEL_OUT1) begin
                addr_hit = 1'b1;
                addr_tgt = TGT_OUT1;
            end else if (shreg[2:1] == SEL_OUT2) begin
                addr_hit = 1'b1;
                addr_tgt = TGT_OUT2;
            end
        end
    end

    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_HOLD:     nxt = ST_HOLD;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall)  nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  nxt = ST_HOLD;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit counter, shifter and target latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            tgt   <= TGT_OUT1;
        end else begin
            if (start_ev || (state == ST_ADDR_ACK && scl_fall)) begin
                cnt <= '0;
            end else if (scl_rise && (state == ST_ADDR || state == ST_DATA)
                         && cnt != CNT_W'(BYTE_W)) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end
            if (state == ST_ADDR && byte_done && addr_hit && !start_ev && !stop_ev)
                tgt <= addr_tgt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_pd <= 1'b0;
        else        sda_pd <= (nxt == ST_ADDR_ACK) || (nxt == ST_DATA_ACK);
    end

    assign byte_valid = (state == ST_DATA) && byte_done && !start_ev && !stop_ev;
    assign byte_q     = shreg[VID_W-1:0];

endmodule

// File: rtl/svid_regs.sv
module svid_regs
    import svid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       vid_strap,
    input  logic             byte_valid,
    input  logic [VID_W-1:0] byte_q,
    input  target_t          tgt,
    output logic [VID_W-1:0] code1,
    output logic [VID_W-1:0] code2,
    output logic             vid_off,
    output logic             code_stb
);

    localparam int OFF_BIT = VID_W - 1;

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code1    <= CODE1_RST;
            code2    <= CODE2_RST;
            vid_off  <= 1'b0;
            code_stb <= 1'b0;
            seen     <= 1'b0;
        end else begin
            code_stb <= byte_valid;
            if (byte_valid) begin
                seen <= 1'b1;
                if (byte_q[OFF_BIT]) begin
                    vid_off <= 1'b1;
                end else begin
                    vid_off <= 1'b0;
                    if (tgt == TGT_OUT1) code1 <= {1'b0, byte_q[OFF_BIT-1:0]};
                    else                 code2 <= {1'b0, byte_q[OFF_BIT-1:0]};
                end
            end else if (!enable_i && !seen) begin
                code1 <= strap_code(vid_strap);
            end
        end
    end

endmodule

// File: rtl/svid_rx.sv
module svid_rx
    import svid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       id_strap_i,
    input  logic [1:0]       vid_strap_i,
    input  logic             enable_i,
    output logic             sda_pd_o,
    output logic [VID_W-1:0] code1_o,
    output logic [VID_W-1:0] code2_o,
    output logic             vid_off_o,
    output logic             code_stb_o
);

    logic [1:0]       bus_s;
    logic             byte_valid;
    logic [VID_W-1:0] byte_q;
    target_t          tgt;

    svid_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (bus_s)
    );

    svid_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (bus_s[1]),
        .sda_s      (bus_s[0]),
        .id_strap   (id_strap_i),
        .sda_pd     (sda_pd_o),
        .byte_valid (byte_valid),
        .byte_q     (byte_q),
        .tgt        (tgt)
    );

    svid_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .vid_strap  (vid_strap_i),
        .byte_valid (byte_valid),
        .byte_q     (byte_q),
        .tgt        (tgt),
        .code1      (code1_o),
        .code2      (code2_o),
        .vid_off    (vid_off_o),
        .code_stb   (code_stb_o)
    );

endmodule

// File: rtl/svid_rx_chk.sv
module svid_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       sda_pd_o,
    input logic [6:0] code1_o,
    input logic [6:0] code2_o,
    input logic       vid_off_o,
    input logic       code_stb_o
);

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb_o |=> !code_stb_o);

    // R4
    stb_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb_o |-> sda_pd_o);

    // R5
    code2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_stb_o |-> $stable(code2_o));

    // R9
    code1_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_stb_o && $past(enable_i)) |-> $stable(code1_o));

    // R6
    off_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb_o && vid_off_o) |-> ($stable(code1_o) && $stable(code2_o)));

endmodule

bind svid_rx svid_rx_chk u_svid_rx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .sda_pd_o   (sda_pd_o),
    .code1_o    (code1_o),
    .code2_o    (code2_o),
    .vid_off_o  (vid_off_o),
    .code_stb_o (code_stb_o)
);

// File: tb/test_svid_rx.sv
module test_svid_rx;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;   // clocks per quarter bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic [1:0] id_strap = 2'b11;
    logic [1:0] vid_strap = 2'b11;
    logic       enable = 1'b0;
    logic       sda_pd;
    logic [6:0] code1, code2;
    logic       vid_off, code_stb;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    // reference model state
    int e1 = 9, e2 = 16, eoff = 0, estb = 0, eseen = 0;
    int due_q[$];
    int tgt_q[$];
    int dat_q[$];

    assign sda_line = m_sda & ~sda_pd;

    svid_rx i_svid_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .id_strap_i  (id_strap),
        .vid_strap_i (vid_strap),
        .enable_i    (enable),
        .sda_pd_o    (sda_pd),
        .code1_o     (code1),
        .code2_o     (code2),
        .vid_off_o   (vid_off),
        .code_stb_o  (code_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // output-1 code for a strap setting, from the boot voltage in 0.1 mV
    function automatic int strap_exp(input int s);
        int v;
        v = 10500 + 1500 * s;
        return (16125 - v) / 125;
    endfunction

    function automatic bit addr_ok(input int a, input int id);
        return ((a & 1) == 0) && ((a >> 5) == 6) && (((a >> 3) & 3) == id)
               && ((((a >> 1) & 3) == 2) || (((a >> 1) & 3) == 1));
    endfunction

    // model and per-cycle comparison
    always @(posedge clk) begin
        cyc++;
        #1;
        if (!rst_n) begin
            e1 = 9; e2 = 16; eoff = 0; estb = 0; eseen = 0;
        end else begin
            estb = 0;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                int d, t;
                d = dat_q.pop_front();
                t = tgt_q.pop_front();
                void'(due_q.pop_front());
                estb = 1;
                eseen = 1;
                if ((d & 64) != 0) eoff = 1;
                else begin
                    eoff = 0;
                    if (t == 1) e1 = d & 63;
                    else        e2 = d & 63;
                end
            end else if (!enable && eseen == 0) begin
                e1 = strap_exp(int'(vid_strap));
            end
        end
        chk(int'(code1) == e1, "R5/R8 code1 per cycle", int'(code1), e1);
        chk(int'(code2) == e2, "R5 code2 per cycle", int'(code2), e2);
        chk(int'(vid_off) == eoff, "R6 off flag per cycle", int'(vid_off), eoff);
        chk(int'(code_stb) == estb, "R7 strobe per cycle", int'(code_stb), estb);
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start;
        if (!m_scl) begin
            m_sda = 1'b1; wq(Q);
            m_scl = 1'b1; wq(Q);
        end else begin
            m_sda = 1'b1; wq(Q);
        end
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_stop;
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input bit b, input bit sched, input int tgt, input int dat);
        m_sda = b;    wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0;
        if (sched) begin
            due_q.push_back(cyc + 3);
            tgt_q.push_back(tgt);
            dat_q.push_back(dat);
        end
        wq(Q);
    endtask

    task automatic ack_slot(input bit exp_ack, input string req);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        chk(sda_pd == exp_ack, req, int'(sda_pd), int'(exp_ack));
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_addr(input int a, output bit hit, output int tgt);
        hit = addr_ok(a, int'(id_strap));
        tgt = (((a >> 1) & 3) == 2) ? 1 : 2;
        for (int i = 7; i >= 0; i--) send_bit(a[i], 1'b0, 0, 0);
        ack_slot(hit, hit ? "R2 address ack" : "R3 address nack");
    endtask

    task automatic xfer(input int a, input int d);
        bit hit;
        int tgt;
        send_start;
        send_addr(a, hit, tgt);
        for (int i = 7; i >= 0; i--) send_bit(d[i], hit && i == 0, tgt, d);
        ack_slot(hit, hit ? "R4 data ack" : "R3 data ignored");
        send_stop;
        wq(4);
    endtask

    initial begin
        bit hit;
        int tgt;
        wq(3);
        chk(code1 == 7'h09 && code2 == 7'h10 && !vid_off && !code_stb && !sda_pd,
            "R10 reset state", int'({code1, code2}), 'h0490);
        rst_n = 1'b1;
        wq(3);

        // R8 strap defaults
        for (int s = 0; s < 4; s++) begin
            vid_strap = 2'(s);
            wq(3);
            chk(int'(code1) == strap_exp(s), "R8 strap default", int'(code1), strap_exp(s));
        end
        vid_strap = 2'b10;
        wq(2);
        enable = 1'b1;
        wq(2);
        vid_strap = 2'b00;
        wq(4);
        chk(code1 == 7'h15, "R9 strap frozen by enable", int'(code1), 'h15);

        // writes with both identity straps high
        xfer('hDC, 'h05);
        chk(code1 == 7'h05, "R5 output-1 write", int'(code1), 'h05);
        xfer('hDA, 'h83);
        chk(code2 == 7'h03 && code1 == 7'h05, "R5 bit 7 ignored, output-2 write", int'(code2), 'h03);
        xfer('hDC, 'h40);
        chk(vid_off && code1 == 7'h05 && code2 == 7'h03, "R6 vid off keeps codes", int'(vid_off), 1);
        xfer('hDA, 'h10);
        chk(!vid_off && code2 == 7'h10, "R6 off cleared by code", int'(vid_off), 0);
        xfer('hDE, 'h22);
        chk(code1 == 7'h05 && code2 == 7'h10, "R3 wrong address ignored", int'(code1), 'h05);
        xfer('hDD, 'h22);
        chk(code1 == 7'h05, "R3 read bit ignored", int'(code1), 'h05);

        // other identity
        id_strap = 2'b01;
        wq(2);
        xfer('hDC, 'h11);
        chk(code1 == 7'h05, "R3 identity mismatch", int'(code1), 'h05);
        xfer('hCC, 'h2F);
        chk(code1 == 7'h2F, "R2 identity 01 accepted", int'(code1), 'h2F);
        xfer('hCA, 'h1F);
        chk(code2 == 7'h1F, "R5 identity 01 output 2", int'(code2), 'h1F);

        // R1 abort by stop in the middle of the data byte
        send_start;
        send_addr('hCC, hit, tgt);
        for (int i = 7; i >= 5; i--) send_bit(1'b0, 1'b0, 0, 0);
        send_stop;
        wq(20);
        chk(code1 == 7'h2F && !code_stb, "R1 stop aborts transfer", int'(code1), 'h2F);

        // R1 repeated start mid-byte then full transfer
        send_start;
        send_addr('hCC, hit, tgt);
        for (int i = 7; i >= 4; i--) send_bit(1'b1, 1'b0, 0, 0);
        send_start;
        send_addr('hCC, hit, tgt);
        for (int i = 7; i >= 0; i--) send_bit(8'h2A >> i, i == 0, tgt, 'h2A);
        ack_slot(1'b1, "R4 data ack after repeated start");
        send_stop;
        wq(4);
        chk(code1 == 7'h2A, "R1 repeated start restarts address", int'(code1), 'h2A);

        // R9 strap ignored after a command even with enable low
        enable = 1'b0;
        vid_strap = 2'b01;
        wq(6);
        chk(code1 == 7'h2A, "R9 strap ignored after command", int'(code1), 'h2A);

        wq(4);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule